// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two unsigned operands one bit per clock, using a single full-adder cell that is reused over time rather than a parallel ripple chain. On an accepted start pulse the two operands are loaded in parallel into two right-shifting registers, and the carry flip-flop is cleared. On each of the following `WIDTH` clocks the full adder combines the least significant bits of both registers with the stored carry. The sum bit is shifted into the most significant end of the first register, and the new carry is stored in the carry flip-flop. After the last shift the first register holds the complete sum in normal bit order, and the carry flip-flop holds the carry-out.

Every flip-flop in the block updates on the falling edge of `clk`, and reset is asynchronous and active low. A small controller walks through three states. In `ST_IDLE` it waits for start. In `ST_RUN` it shifts and counts bit positions. In `ST_FIN` it holds the result for one cycle and signals completion. The transitions are: `IDLE->RUN` on start; `RUN->RUN` while bits remain; `RUN->FIN` after the last bit; `FIN->RUN` on start (back-to-back); `FIN->IDLE` otherwise. `busy` and `done` are decoded from the state. The result outputs keep their value until the next accepted start.

Top module: `bitserial_adder`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `sum` and `cout` are all 0.
- R2: A start sampled while `busy` is low loads both operands, clears the stored carry, and raises `busy` from the next cycle on. A preceding carry-out of 1 does not leak into the next addition.
- R3: `busy` stays high for exactly `WIDTH` (8) cycles per operation, and `busy` and `done` are never high together.
- R4: `done` is high for exactly one cycle, immediately after the last `busy` cycle.
- R5: While `done` is high, `sum` equals (a + b) mod 2^WIDTH of the operands captured at the accepted start. Bit 0 of the sum is on `sum[0]`.
- R6: While `done` is high, `cout` equals bit `WIDTH` of the unsigned sum a + b.
- R7: A start while `busy` is high is ignored. The running operation completes with its original operands and timing.
- R8: After `done`, `sum` and `cout` hold their value while no start is given, even if the operand inputs change.
- R9: A start given in the cycle where `done` is high is accepted, and a new operation begins with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an addition |
| a_in | input | WIDTH | First operand, loaded on accepted start |
| b_in | input | WIDTH | Second operand, loaded on accepted start |
| busy | output | 1 | High during the WIDTH add cycles |
| done | output | 1 | One-cycle pulse when the result is ready |
| sum | output | WIDTH | Sum register contents |
| cout | output | 1 | Stored carry-out |

## Verification
Start is accepted on the falling edge that follows its assertion. `busy` is therefore due on the next sample, stays high for eight samples, and is followed by `done` together with the final `sum` and `cout` on the ninth sample. The bench drives inputs just after the rising edge and samples there too, half a period away from the falling edge where the design updates. Each task counts those samples one by one and checks `busy`, `done` and the result exactly at the cycle where they are due, not by polling for them. The bound checker counts busy cycles with its own counter, and it latches its own expected sum on the same falling edge as the load.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } bsa_state_t;
endpackage

// File: rtl/bsa_shreg.sv
// Right-shifting register with parallel load; serial data enters at the MSB.
module bsa_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_next;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == WIDTH - 1) begin : g_top
            always_comb begin
                if (load)       q_next[i] = par_in[i];
                else if (shift) q_next[i] = ser_in;
                else            q_next[i] = q[i];
            end
        end else begin : g_mid
            always_comb begin
                if (load)       q_next[i] = par_in[i];
                else if (shift) q_next[i] = q[i+1];
                else            q_next[i] = q[i];
            end
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end
endmodule

// File: rtl/bsa_fa.sv
// Single full-adder cell reused on every bit position.
module bsa_fa (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic co
);
    always_comb begin
        s  = x ^ y ^ cin;
        co = (x & y) | (cin & (x ^ y));
    end
endmodule

// File: rtl/bsa_ctrl.sv
// Sequencer: idle, run for WIDTH bit cycles, finish for one cycle.
module bsa_ctrl
    import bsa_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic shift,
    output logic busy,
    output logic done
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    bsa_state_t state, state_next;
    logic [CW-1:0] bit_idx;

    always_comb begin
        state_next = state;
        unique case (state)
            ST_IDLE: if (start) state_next = ST_RUN;
            ST_RUN:  if (bit_idx == LAST) state_next = ST_FIN;
            ST_FIN:  state_next = start ? ST_RUN : ST_IDLE;
            default: state_next = ST_IDLE;
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
        end else begin
            state <= state_next;
            if (state == ST_RUN) bit_idx <= bit_idx + 1'b1;
            else                 bit_idx <= '0;
        end
    end

    always_comb begin
        load  = 1'b0;
        shift = 1'b0;
        busy  = 1'b0;
        done  = 1'b0;
        unique case (state)
            ST_IDLE: load = start;
            ST_RUN: begin
                shift = 1'b1;
                busy  = 1'b1;
            end
            ST_FIN: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bitserial_adder.sv
module bitserial_adder #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic             load, shift;
    logic [WIDTH-1:0] acc_q, add_q;
    logic             fa_s, fa_co;
    logic             carry_q;

    bsa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .shift (shift),
        .busy  (busy),
        .done  (done)
    );

    // Accumulator: operand A in, sum bits return at the MSB end.
    bsa_shreg #(.WIDTH(WIDTH)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .shift  (shift),
        .par_in (a_in),
        .ser_in (fa_s),
        .q      (acc_q)
    );

    // Addend: operand B, zero-filled from the MSB end.
    bsa_shreg #(.WIDTH(WIDTH)) u_addend (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .shift  (shift),
        .par_in (b_in),
        .ser_in (1'b0),
        .q      (add_q)
    );

    bsa_fa u_fa (
        .x   (acc_q[0]),
        .y   (add_q[0]),
        .cin (carry_q),
        .s   (fa_s),
        .co  (fa_co)
    );

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)     carry_q <= 1'b0;
        else if (load)  carry_q <= 1'b0;
        else if (shift) carry_q <= fa_co;
    end

    assign sum  = acc_q;
    assign cout = carry_q;
endmodule

// File: rtl/bitserial_adder_chk.sv
module bitserial_adder_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);
    localparam int RW = $clog2(WIDTH + 2);

    logic [RW-1:0] run_cnt;
    logic [WIDTH:0] exp_total;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            exp_total <= '0;
        end else begin
            run_cnt <= busy ? run_cnt + 1'b1 : '0;
            if (start && !busy)
                exp_total <= {1'b0, a_in} + {1'b0, b_in};
        end
    end

    a_r2_busy_follows_start: assert property (@(negedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r3_busy_length: assert property (@(negedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == RW'(WIDTH)));

    a_r3_not_both: assert property (@(negedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r4_done_single: assert property (@(negedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_done_after_busy: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    a_r5_sum_value: assert property (@(negedge clk) disable iff (!rst_n)
        done |-> (sum == exp_total[WIDTH-1:0]));

    a_r6_carry_value: assert property (@(negedge clk) disable iff (!rst_n)
        done |-> (cout == exp_total[WIDTH]));
endmodule

bind bitserial_adder bitserial_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .a_in  (a_in),
    .b_in  (b_in),
    .busy  (busy),
    .done  (done),
    .sum   (sum),
    .cout  (cout)
);

// File: tb/bitserial_adder_bench.sv
module bitserial_adder_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         busy, done, cout;
    logic [W-1:0] sum;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bitserial_adder #(.WIDTH(W)) u_bitserial_adder (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
        .busy(busy), .done(done), .sum(sum), .cout(cout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive start just after a rising edge; returns one rising edge later (P1).
    task automatic pulse_start(input logic [W-1:0] a, input logic [W-1:0] b);
        #1;
        start = 1'b1; a_in = a; b_in = b;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    // Called at P1: checks busy for W samples and the result at sample W+1.
    task automatic watch_op(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] tot;
        tot = {1'b0, a} + {1'b0, b};
        for (int i = 0; i < W; i++) begin
            chk(busy === 1'b1, "R3 busy", int'(busy), 1);
            chk(done === 1'b0, "R3 no done while busy", int'(done), 0);
            @(posedge clk); #1;
        end
        chk(busy === 1'b0, "R3 busy drops", int'(busy), 0);
        chk(done === 1'b1, "R4 done", int'(done), 1);
        chk(sum === tot[W-1:0], "R5 sum", int'(sum), int'(tot[W-1:0]));
        chk(cout === tot[W], "R6 cout", int'(cout), int'(tot[W]));
    endtask

    task automatic t_reset();
        chk(busy === 1'b0 && done === 1'b0, "R1 flags in reset", int'({busy, done}), 0);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(busy === 1'b0 && done === 1'b0, "R1 flags after reset", int'({busy, done}), 0);
        chk(sum === '0 && cout === 1'b0, "R1 result after reset", int'({cout, sum}), 0);
    endtask

    task automatic t_basic(input logic [W-1:0] a, input logic [W-1:0] b);
        pulse_start(a, b);
        watch_op(a, b);
        @(posedge clk); #1;
        chk(done === 1'b0, "R4 done single cycle", int'(done), 0);
    endtask

    task automatic t_carry_clear();
        t_basic(8'hFF, 8'h01);
        pulse_start(8'h00, 8'h00);
        chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
        watch_op(8'h00, 8'h00);
        chk(cout === 1'b0 && sum === 8'h00, "R2 carry cleared", int'({cout, sum}), 0);
    endtask

    task automatic t_ignore();
        logic [W:0] tot;
        tot = 9'h0C3 + 9'h07E;
        pulse_start(8'hC3, 8'h7E);
        @(posedge clk); #1;
        start = 1'b1; a_in = 8'h11; b_in = 8'h22;
        @(posedge clk); #1;
        start = 1'b0;
        chk(busy === 1'b1, "R7 still busy", int'(busy), 1);
        repeat (W - 2) @(posedge clk);
        #1;
        chk(done === 1'b1, "R7 timing kept", int'(done), 1);
        chk(sum === tot[W-1:0] && cout === tot[W], "R7 original result",
            int'({cout, sum}), int'(tot));
    endtask

    task automatic t_hold();
        logic [W:0] tot;
        tot = 9'h0A7 + 9'h0B9;
        pulse_start(8'hA7, 8'hB9);
        watch_op(8'hA7, 8'hB9);
        a_in = 8'h5A; b_in = 8'h33;
        repeat (3) begin
            @(posedge clk); #1;
            chk(sum === tot[W-1:0] && cout === tot[W] && busy === 1'b0,
                "R8 result held", int'({cout, sum}), int'(tot));
        end
    endtask

    task automatic t_back_to_back();
        pulse_start(8'h81, 8'h90);
        watch_op(8'h81, 8'h90);
        start = 1'b1; a_in = 8'h6D; b_in = 8'h29;
        @(posedge clk); #1;
        start = 1'b0;
        chk(busy === 1'b1, "R9 restart in done cycle", int'(busy), 1);
        watch_op(8'h6D, 8'h29);
    endtask

    initial begin
        t_reset();
        t_basic(8'h3C, 8'h51);
        t_basic(8'hAA, 8'h55);
        t_basic(8'hF0, 8'h1F);
        t_carry_clear();
        t_ignore();
        t_hold();
        t_back_to_back();
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule